// File: doc/BRIEF.md
# Conditional Branch Resolver

This block finishes a conditional relative jump that the front end has already fetched and split into opcode bytes and displacement bytes. It works out which condition the opcode selects and tests it against the status flags, or against the count register for the count-is-zero variant. It then decides whether the jump is taken and produces the address of the next instruction. If the encoding is illegal it raises an invalid-opcode fault, and if the target address is illegal it raises a general-protection fault.

Every request is one cycle wide and carries the instruction's own address, the processor mode, the operand-size and address-size codes, a lock-prefix flag and the code segment limit. Exactly one registered result comes back one clock later. A consumer reads `taken_o`, `fault_gp_o` and `fault_ud_o` as mutually exclusive; when all three are low, the result is a plain fall-through to `next_ip_o`.

Top module: `cbr_unit`

## Requirements
- R1: One clock after `valid_i` is high, `valid_o` is high, and at most one of `taken_o`, `fault_gp_o`, `fault_ud_o` is set. When no request was presented, `valid_o` and all three outcome bits are low. After reset every output is zero.
- R2: Three encodings are accepted, each with its own instruction length:
  - `op0_i` in 70h..7Fh is the short form, with an 8-bit displacement in `disp_i[7:0]`; length 2.
  - `op0_i`=0Fh with `op1_i` in 80h..8Fh is the near form; length 6, using `disp_i[31:0]`, or length 4 using only `disp_i[15:0]` when the operand size is 16 outside 64-bit mode.
  - `op0_i`=E3h is the count test, with an 8-bit displacement; length 2.
  - A jump that is not taken reports `next_ip_o` = `ip_i` + length.
- R3: The low nibble of the condition opcode picks the test, using `flags_i` bit 0=CF, 1=PF, 2=ZF, 3=SF, 4=OF:
  - Each even nibble has a base test, and the odd nibble one above it tests the inverse of that base test.
  - The base tests are: 0 OF; 2 CF; 4 ZF; 6 CF|ZF; 8 SF; A PF; C SF≠OF; E ZF|(SF≠OF).
- R4: Opcode E3h ignores the flags. It is taken when the low 16, 32 or 64 bits of `count_i` are zero, for `addr_size_i` = 0, 1 or 2 respectively.
- R5: The taken target is `ip_i` + length + the sign-extended displacement. Outside 64-bit mode, both the target and the fall-through address wrap at 32 bits. With `op_size_i`=0 (16-bit) outside 64-bit mode, the target is also masked to its low 16 bits.
- R6: Outside 64-bit mode (`mode_i` 0 = real, 1 = protected), a taken target above `cs_limit_i` raises `fault_gp_o` with `taken_o` low. Whenever a fault is raised, `next_ip_o` equals `ip_i`. A fall-through is never limit-checked.
- R7: In 64-bit mode (`mode_i`=2), the segment limit is ignored. A taken target whose bits 63..47 are not all equal raises `fault_gp_o`.
- R8: `lock_i` high raises `fault_ud_o` for any opcode.
- R9: The following raise `fault_ud_o` instead of a jump:
  - an unrecognised opcode;
  - `mode_i`=3;
  - a size code of 3;
  - a 64-bit size code outside 64-bit mode;
  - in 64-bit mode, the near form with `op_size_i`=0 or E3h with `addr_size_i`=0.
  - Illegal encodings take priority over a general-protection fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| op0_i | input | 8 | First opcode byte |
| op1_i | input | 8 | Second opcode byte (near form) |
| disp_i | input | 32 | Displacement bytes, little end in bit 0 |
| ip_i | input | 64 | Address of the jump instruction |
| flags_i | input | 5 | {OF, SF, ZF, PF, CF} |
| count_i | input | 64 | Count register |
| mode_i | input | 2 | 0 real, 1 protected/compatibility, 2 64-bit |
| op_size_i | input | 2 | Operand size: 0=16, 1=32, 2=64 |
| addr_size_i | input | 2 | Address size: 0=16, 1=32, 2=64 |
| lock_i | input | 1 | Lock prefix present |
| cs_limit_i | input | 32 | Code segment limit |
| valid_o | output | 1 | Result present |
| taken_o | output | 1 | Jump taken |
| next_ip_o | output | 64 | Next instruction address |
| fault_gp_o | output | 1 | General-protection fault |
| fault_ud_o | output | 1 | Invalid-opcode fault |

## Verification
Every result of this block, including both faults, is due exactly one clock after the request is presented; there is no other latency. The bench drives each request on a falling edge and reads the matching result on the next falling edge, while the following request is already being driven. The run is therefore fully back-to-back, and each check samples only the single result owed to the request before it. Reset state and idle cycles are checked separately, on falling edges with no request pending.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {MODE_REAL = 2'd0, MODE_PROT = 2'd1, MODE_LONG = 2'd2, MODE_BAD = 2'd3} cpu_mode_e;
  typedef enum logic [1:0] {SZ_16 = 2'd0, SZ_32 = 2'd1, SZ_64 = 2'd2, SZ_BAD = 2'd3} size_e;
  typedef enum logic [1:0] {FORM_NONE, FORM_SHORT, FORM_NEAR, FORM_CXZ} form_e;
  typedef enum logic [1:0] {DISP8, DISP16, DISP32} disp_e;
  localparam int FLAG_W = 5;
  localparam int FL_CF = 0;
  localparam int FL_PF = 1;
  localparam int FL_ZF = 2;
  localparam int FL_SF = 3;
  localparam int FL_OF = 4;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
  import cbr_pkg::*;
(
  input  logic [7:0] op0_i,
  input  logic [7:0] op1_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] op_size_i,
  input  logic [1:0] addr_size_i,
  input  logic       lock_i,
  output form_e      form_o,
  output logic [3:0] cc_o,
  output disp_e      disp_sel_o,
  output logic [2:0] len_o,
  output logic       long_o,
  output logic       wrap16_o,
  output logic       ud_o
);
  logic long_m;
  assign long_m = (cpu_mode_e'(mode_i) == MODE_LONG);

  always_comb begin
    form_o = FORM_NONE;
    cc_o   = op0_i[3:0];
    if (op0_i[7:4] == 4'h7) begin
      form_o = FORM_SHORT;
    end else if (op0_i == 8'h0F && op1_i[7:4] == 4'h8) begin
      form_o = FORM_NEAR;
      cc_o   = op1_i[3:0];
    end else if (op0_i == 8'hE3) begin
      form_o = FORM_CXZ;
    end
  end

  always_comb begin
    disp_sel_o = DISP8;
    len_o      = 3'd2;
    if (form_o == FORM_NEAR) begin
      if (!long_m && size_e'(op_size_i) == SZ_16) begin
        disp_sel_o = DISP16;
        len_o      = 3'd4;
      end else begin
        disp_sel_o = DISP32;
        len_o      = 3'd6;
      end
    end
  end

  // illegal encodings for the current mode
  always_comb begin
    ud_o = lock_i || form_o == FORM_NONE
        || cpu_mode_e'(mode_i) == MODE_BAD
        || size_e'(op_size_i) == SZ_BAD || size_e'(addr_size_i) == SZ_BAD;
    if (!long_m && (size_e'(op_size_i) == SZ_64 || size_e'(addr_size_i) == SZ_64)) ud_o = 1'b1;
    if (long_m && form_o == FORM_NEAR && size_e'(op_size_i) == SZ_16) ud_o = 1'b1;
    if (long_m && form_o == FORM_CXZ && size_e'(addr_size_i) == SZ_16) ud_o = 1'b1;
  end

  assign long_o   = long_m;
  assign wrap16_o = !long_m && size_e'(op_size_i) == SZ_16;
endmodule

// File: rtl/cbr_cond.sv
module cbr_cond
  import cbr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  form_e              form_i,
  input  logic [3:0]         cc_i,
  input  logic [FLAG_W-1:0]  flags_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [1:0]         addr_size_i,
  output logic               cond_o
);
  logic cf, pf, zf, sf, of, base, cnt_zero;
  assign cf = flags_i[FL_CF];
  assign pf = flags_i[FL_PF];
  assign zf = flags_i[FL_ZF];
  assign sf = flags_i[FL_SF];
  assign of = flags_i[FL_OF];

  // even nibble tests base, odd nibble tests its inverse
  always_comb begin
    unique case (cc_i[3:1])
      3'd0: base = of;
      3'd1: base = cf;
      3'd2: base = zf;
      3'd3: base = cf | zf;
      3'd4: base = sf;
      3'd5: base = pf;
      3'd6: base = sf ^ of;
      default: base = zf | (sf ^ of);
    endcase
  end

  always_comb begin
    unique case (size_e'(addr_size_i))
      SZ_16:   cnt_zero = (count_i[15:0] == '0);
      SZ_32:   cnt_zero = (count_i[31:0] == '0);
      default: cnt_zero = (count_i == '0);
    endcase
  end

  assign cond_o = (form_i == FORM_CXZ) ? cnt_zero : (base ^ cc_i[0]);
endmodule

// File: rtl/cbr_target.sv
module cbr_target
  import cbr_pkg::*;
#(
  parameter int IP_W  = 64,
  parameter int VA_W  = 48,
  parameter int LIM_W = 32
) (
  input  logic [IP_W-1:0]  ip_i,
  input  logic [31:0]      disp_i,
  input  disp_e            disp_sel_i,
  input  logic [2:0]       len_i,
  input  logic             long_i,
  input  logic             wrap16_i,
  input  logic [LIM_W-1:0] cs_limit_i,
  output logic [IP_W-1:0]  fall_ip_o,
  output logic [IP_W-1:0]  tgt_ip_o,
  output logic             tgt_bad_o
);
  localparam int HI_W = IP_W - VA_W + 1;

  logic [IP_W-1:0] sdisp, fall_raw, tgt_raw;
  logic [HI_W-1:0] hi_bits;

  always_comb begin
    unique case (disp_sel_i)
      DISP8:   sdisp = {{(IP_W-8){disp_i[7]}}, disp_i[7:0]};
      DISP16:  sdisp = {{(IP_W-16){disp_i[15]}}, disp_i[15:0]};
      default: sdisp = {{(IP_W-32){disp_i[31]}}, disp_i};
    endcase
  end

  assign fall_raw = ip_i + {{(IP_W-3){1'b0}}, len_i};
  assign tgt_raw  = fall_raw + sdisp;

  always_comb begin
    if (long_i) begin
      fall_ip_o = fall_raw;
      tgt_ip_o  = tgt_raw;
    end else begin
      fall_ip_o = {{(IP_W-LIM_W){1'b0}}, fall_raw[LIM_W-1:0]};
      tgt_ip_o  = {{(IP_W-LIM_W){1'b0}}, tgt_raw[LIM_W-1:0]};
      if (wrap16_i) tgt_ip_o[LIM_W-1:16] = '0;
    end
  end

  assign hi_bits   = tgt_ip_o[IP_W-1:VA_W-1];
  assign tgt_bad_o = long_i ? !((&hi_bits) || !(|hi_bits))
                            : (tgt_ip_o[LIM_W-1:0] > cs_limit_i);
endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
  import cbr_pkg::*;
#(
  parameter int IP_W  = 64,
  parameter int VA_W  = 48,
  parameter int LIM_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        op0_i,
  input  logic [7:0]        op1_i,
  input  logic [31:0]       disp_i,
  input  logic [IP_W-1:0]   ip_i,
  input  logic [4:0]        flags_i,
  input  logic [IP_W-1:0]   count_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        op_size_i,
  input  logic [1:0]        addr_size_i,
  input  logic              lock_i,
  input  logic [LIM_W-1:0]  cs_limit_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [IP_W-1:0]   next_ip_o,
  output logic              fault_gp_o,
  output logic              fault_ud_o
);
  form_e           form;
  disp_e           disp_sel;
  logic [3:0]      cc;
  logic [2:0]      len;
  logic            is_long, wrap16, ud, cond, tgt_bad;
  logic [IP_W-1:0] fall_ip, tgt_ip;
  logic            take_d, gp_d, ud_d;
  logic [IP_W-1:0] nip_d;

  cbr_decode u_dec (
    .op0_i(op0_i), .op1_i(op1_i), .mode_i(mode_i), .op_size_i(op_size_i),
    .addr_size_i(addr_size_i), .lock_i(lock_i), .form_o(form), .cc_o(cc),
    .disp_sel_o(disp_sel), .len_o(len), .long_o(is_long), .wrap16_o(wrap16), .ud_o(ud)
  );

  cbr_cond #(.CNT_W(IP_W)) u_cond (
    .form_i(form), .cc_i(cc), .flags_i(flags_i), .count_i(count_i),
    .addr_size_i(addr_size_i), .cond_o(cond)
  );

  cbr_target #(.IP_W(IP_W), .VA_W(VA_W), .LIM_W(LIM_W)) u_tgt (
    .ip_i(ip_i), .disp_i(disp_i), .disp_sel_i(disp_sel), .len_i(len),
    .long_i(is_long), .wrap16_i(wrap16), .cs_limit_i(cs_limit_i),
    .fall_ip_o(fall_ip), .tgt_ip_o(tgt_ip), .tgt_bad_o(tgt_bad)
  );

  // ud outranks gp; a fault leaves the pointer on the jump itself
  always_comb begin
    ud_d   = ud;
    gp_d   = !ud && cond && tgt_bad;
    take_d = !ud && cond && !tgt_bad;
    if (ud_d || gp_d) nip_d = ip_i;
    else if (take_d)  nip_d = tgt_ip;
    else              nip_d = fall_ip;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      taken_o    <= 1'b0;
      fault_gp_o <= 1'b0;
      fault_ud_o <= 1'b0;
      next_ip_o  <= '0;
    end else begin
      valid_o    <= valid_i;
      taken_o    <= valid_i && take_d;
      fault_gp_o <= valid_i && gp_d;
      fault_ud_o <= valid_i && ud_d;
      if (valid_i) next_ip_o <= nip_d;
    end
  end
endmodule

// File: rtl/cbr_unit_chk.sv
module cbr_unit_chk #(
  parameter int IP_W  = 64,
  parameter int VA_W  = 48,
  parameter int LIM_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [7:0]        op0_i,
  input logic [7:0]        op1_i,
  input logic [31:0]       disp_i,
  input logic [IP_W-1:0]   ip_i,
  input logic [4:0]        flags_i,
  input logic [IP_W-1:0]   count_i,
  input logic [1:0]        mode_i,
  input logic [1:0]        op_size_i,
  input logic [1:0]        addr_size_i,
  input logic              lock_i,
  input logic [LIM_W-1:0]  cs_limit_i,
  input logic              valid_o,
  input logic              taken_o,
  input logic [IP_W-1:0]   next_ip_o,
  input logic              fault_gp_o,
  input logic              fault_ud_o
);
  logic canon_o;
  assign canon_o = (&next_ip_o[IP_W-1:VA_W-1]) || !(|next_ip_o[IP_W-1:VA_W-1]);

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_one_outcome_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones({taken_o, fault_gp_o, fault_ud_o}) <= 1);
  p_quiet_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(taken_o || fault_gp_o || fault_ud_o));
  p_fault_keeps_ip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (!(fault_gp_o || fault_ud_o) || next_ip_o == $past(ip_i)));
  p_wrap16_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i != 2'd2 && op_size_i == 2'd0 |=> (!taken_o || next_ip_o[IP_W-1:16] == '0));
  p_long_canon_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 2'd2 |=> (!taken_o || canon_o));
  p_lock_ud_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && lock_i |=> fault_ud_o);
endmodule

bind cbr_unit cbr_unit_chk #(.IP_W(IP_W), .VA_W(VA_W), .LIM_W(LIM_W)) u_chk (.*);

// File: tb/sim_cbr_unit.sv
module sim_cbr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;

  typedef struct packed {
    logic [3:0]  req;
    logic [7:0]  op0;
    logic [7:0]  op1;
    logic [31:0] disp;
    logic [63:0] ip;
    logic [4:0]  flg;   // {OF,SF,ZF,PF,CF}
    logic [63:0] cnt;
    logic [1:0]  md;
    logic [1:0]  osz;
    logic [1:0]  asz;
    logic        lck;
    logic [31:0] lim;
    logic        tk;
    logic        gp;
    logic        ud;
    logic [63:0] nip;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{4'd3, 8'h74, 8'h00, 32'h10, 64'h1000, 5'b00100, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'h1012}, // R3 ZF
    '{4'd2, 8'h74, 8'h00, 32'h10, 64'h1000, 5'b00000, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 64'h1002}, // R2 fall
    '{4'd3, 8'h7F, 8'h00, 32'hF0, 64'h1000, 5'b11000, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'h0FF2}, // R3 greater
    '{4'd3, 8'h7C, 8'h00, 32'h05, 64'h1000, 5'b01000, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'h1007}, // R3 less
    '{4'd3, 8'h77, 8'h00, 32'h10, 64'h1000, 5'b00001, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 64'h1002}, // R3 above
    '{4'd3, 8'h7A, 8'h00, 32'h7F, 64'h1000, 5'b00010, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'h1081}, // R3 PF
    '{4'd3, 8'h71, 8'h00, 32'h10, 64'h1000, 5'b00000, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'h1012}, // R3 !OF
    '{4'd3, 8'h70, 8'h00, 32'h10, 64'h1000, 5'b10000, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'h1012}, // R3 OF
    '{4'd3, 8'h7E, 8'h00, 32'h10, 64'h1000, 5'b11000, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 64'h1002}, // R3 less-eq
    '{4'd3, 8'h78, 8'h00, 32'h10, 64'h1000, 5'b01000, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'h1012}, // R3 SF
    '{4'd3, 8'h76, 8'h00, 32'h10, 64'h1000, 5'b00100, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'h1012}, // R3 CF|ZF
    '{4'd3, 8'h73, 8'h00, 32'h10, 64'h1000, 5'b00000, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'h1012}, // R3 !CF
    '{4'd3, 8'h7B, 8'h00, 32'h10, 64'h1000, 5'b00010, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 64'h1002}, // R3 !PF
    '{4'd3, 8'h7D, 8'h00, 32'h10, 64'h1000, 5'b10000, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 64'h1002}, // R3 SF=OF
    '{4'd2, 8'h0F, 8'h85, 32'h0000_1000, 64'h1000, 5'b00000, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'h2006}, // R2 near32
    '{4'd2, 8'h0F, 8'h85, 32'h1234_FF00, 64'h0100, 5'b00000, 64'h0, 2'd0, 2'd0, 2'd0, 1'b0, 32'h0000_FFFF, 1'b1, 1'b0, 1'b0, 64'h0004}, // R2 near16
    '{4'd5, 8'h74, 8'h00, 32'h7F, 64'hFFF0, 5'b00100, 64'h0, 2'd0, 2'd0, 2'd0, 1'b0, 32'h0000_FFFF, 1'b1, 1'b0, 1'b0, 64'h0071}, // R5 16-bit mask
    '{4'd6, 8'h0F, 8'h84, 32'h200, 64'h1F00, 5'b00100, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'h0000_1FFF, 1'b0, 1'b1, 1'b0, 64'h1F00}, // R6 limit gp
    '{4'd6, 8'h0F, 8'h84, 32'h200, 64'h1F00, 5'b00000, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'h0000_1FFF, 1'b0, 1'b0, 1'b0, 64'h1F06}, // R6 fall no check
    '{4'd4, 8'hE3, 8'h00, 32'h10, 64'h1000, 5'b11111, 64'hFFFF_FFFF_0000_0000, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'h1012}, // R4 cnt32
    '{4'd4, 8'hE3, 8'h00, 32'h10, 64'h1000, 5'b00000, 64'h0000_0000_0001_0000, 2'd1, 2'd1, 2'd0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'h1012}, // R4 cnt16
    '{4'd4, 8'hE3, 8'h00, 32'h10, 64'h1000, 5'b00000, 64'h0000_0000_0001_0000, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 64'h1002}, // R4 cnt32 nz
    '{4'd4, 8'hE3, 8'h00, 32'h10, 64'h1000, 5'b00000, 64'h0000_0001_0000_0000, 2'd2, 2'd2, 2'd2, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 64'h1002}, // R4 cnt64 nz
    '{4'd7, 8'h74, 8'h00, 32'h7F, 64'h0000_7FFF_FFFF_FFF0, 5'b00100, 64'h0, 2'd2, 2'd2, 2'd2, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 64'h0000_7FFF_FFFF_FFF0}, // R7 noncanon
    '{4'd7, 8'h74, 8'h00, 32'h10, 64'hFFFF_8000_0000_1000, 5'b00100, 64'h0, 2'd2, 2'd2, 2'd2, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 64'hFFFF_8000_0000_1012}, // R7 canon, limit ignored
    '{4'd8, 8'h74, 8'h00, 32'h10, 64'h1000, 5'b00100, 64'h0, 2'd1, 2'd1, 2'd1, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 64'h1000}, // R8 lock
    '{4'd9, 8'h90, 8'h00, 32'h10, 64'h1000, 5'b00100, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 64'h1000}, // R9 unknown
    '{4'd9, 8'h0F, 8'h84, 32'h10, 64'h1000, 5'b00100, 64'h0, 2'd2, 2'd0, 2'd2, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 64'h1000}, // R9 long near16
    '{4'd9, 8'hE3, 8'h00, 32'h10, 64'h1000, 5'b00000, 64'h0, 2'd2, 2'd2, 2'd0, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 64'h1000}, // R9 long cx16
    '{4'd9, 8'h74, 8'h00, 32'h10, 64'h1000, 5'b00100, 64'h0, 2'd1, 2'd2, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 64'h1000}, // R9 size64 legacy
    '{4'd9, 8'h74, 8'h00, 32'h10, 64'h1000, 5'b00100, 64'h0, 2'd3, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 64'h1000}, // R9 bad mode
    '{4'd9, 8'h0F, 8'h90, 32'h10, 64'h1000, 5'b00100, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 64'h1000}, // R9 0F 90
    '{4'd5, 8'h0F, 8'h84, 32'h20, 64'hFFFF_FFF0, 5'b00100, 64'h0, 2'd1, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'h0016}  // R5 32-bit wrap
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  op0_i = '0, op1_i = '0;
  logic [31:0] disp_i = '0;
  logic [63:0] ip_i = '0, count_i = '0;
  logic [4:0]  flags_i = '0;
  logic [1:0]  mode_i = '0, op_size_i = '0, addr_size_i = '0;
  logic        lock_i = 1'b0;
  logic [31:0] cs_limit_i = '0;
  logic        valid_o, taken_o, fault_gp_o, fault_ud_o;
  logic [63:0] next_ip_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cbr_unit u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    valid_i = 1'b1; op0_i = v.op0; op1_i = v.op1; disp_i = v.disp; ip_i = v.ip;
    flags_i = v.flg; count_i = v.cnt; mode_i = v.md; op_size_i = v.osz;
    addr_size_i = v.asz; lock_i = v.lck; cs_limit_i = v.lim;
  endtask

  task automatic check_vec(input int i);
    vec_t v = TBL[i];
    string s;
    s = $sformatf("R%0d vec%0d", v.req, i);
    chk({"R1 valid ", s}, {63'd0, valid_o}, 64'd1);
    chk({"taken ", s}, {63'd0, taken_o}, {63'd0, v.tk});
    chk({"gp ", s}, {63'd0, fault_gp_o}, {63'd0, v.gp});
    chk({"ud ", s}, {63'd0, fault_ud_o}, {63'd0, v.ud});
    chk({"next_ip ", s}, next_ip_o, v.nip);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 reset valid", {63'd0, valid_o}, 64'd0);
    chk("R1 reset outcome", {61'd0, taken_o, fault_gp_o, fault_ud_o}, 64'd0);
    chk("R1 reset next_ip", next_ip_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle valid", {63'd0, valid_o}, 64'd0);
    // back-to-back table walk, result checked one cycle after drive
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk_i);
      if (i + 1 < NV) drive(TBL[i+1]);
      else valid_i = 1'b0;
      check_vec(i);
      if (i + 1 < NV) begin
        @(negedge clk_i);
        check_vec(i + 1);
        i++;
        valid_i = 1'b0;
      end
    end
    // R1 idle after traffic: the lock request below must not leak without valid
    lock_i = 1'b1; op0_i = 8'h90;
    @(negedge clk_i);
    chk("R1 idle after run valid", {63'd0, valid_o}, 64'd0);
    chk("R1 idle after run outcome", {61'd0, taken_o, fault_gp_o, fault_ud_o}, 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule